// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is one compare channel that sits beside a timer counter. It holds a compare value that the CPU writes, and it checks that value against the count on every timer-clock enable pulse. When the count equals the compare value, the channel sets a sticky match flag and updates an internal output bit. A two-bit output mode chooses whether the match sets, clears or toggles that bit. The same mode chooses whether the pin follows the output bit or the general port value.

In the two PWM waveform modes the compare value is double buffered. CPU writes land in a shadow register, and the live compare register copies it only at the end of a period. In fast PWM that is the tick at TOP; in phase-correct PWM it is the tick at BOTTOM. In normal and clear-on-match modes the CPU writes the live register directly. A force strobe, honoured only outside PWM, applies the match action without raising the flag. A CPU write to the counter suppresses the first compare evaluation that follows it, even when the timer clock is stopped. The counter, interrupt routing and pin direction logic are outside this block.

Top module: `ocu_channel`

## Requirements
- R1: In normal (wave_mode 00) and clear-on-match (01) modes, a CPU compare write updates cmp_active on the next clock edge.
- R2: In fast PWM (10) a compare write goes to a shadow register, which loads into cmp_active only on a tick with cnt_at_top high. In phase-correct PWM (11) it loads only on a tick with cnt_at_bottom high.
- R3: Outside PWM, a compare hit applies out_mode to oc_bit on the edge that samples the tick: 01 toggles, 10 clears, 11 sets, 00 leaves it unchanged.
- R4: force_stb outside PWM applies the same out_mode action to oc_bit without setting match_flag or match_pulse. In PWM modes force_stb has no effect.
- R5: A cnt_wr pulse blocks the hit of the first tick in a later cycle, however many idle cycles pass before that tick. The tick after it compares normally.
- R6: match_flag is set by an unblocked hit and stays set until flag_clr. A hit in the same cycle as flag_clr leaves the flag set. match_pulse is high for one cycle after each unblocked hit.
- R7: out_mode is not buffered: a change takes effect at the very next hit.
- R8: pin_out equals port_val when out_mode is 00, and also when it is 01 in a PWM mode. Otherwise pin_out equals oc_bit.
- R9: In PWM modes, out_mode 10 clears oc_bit on a hit and sets it on a tick at BOTTOM. Out_mode 11 does the opposite, and a hit takes priority over BOTTOM. Out_mode 01 leaves oc_bit unchanged.
- R10: Reset clears oc_bit, match_flag and cmp_active. A change of wave_mode alone leaves oc_bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer-clock enable, one compare per pulse |
| cnt_val | input | W | Current counter value |
| cnt_at_top | input | 1 | Counter is at TOP this tick |
| cnt_at_bottom | input | 1 | Counter is at BOTTOM this tick |
| wave_mode | input | 2 | 00 normal, 01 clear-on-match, 10 fast PWM, 11 phase-correct PWM |
| out_mode | input | 2 | Compare-output action selector |
| cmp_wr | input | 1 | CPU compare-value write strobe |
| cmp_wdata | input | W | CPU compare-value write data |
| cnt_wr | input | 1 | CPU counter write seen by the counter |
| force_stb | input | 1 | Force-compare strobe |
| flag_clr | input | 1 | CPU write of one to the match flag |
| port_val | input | 1 | General port output value |
| cmp_active | output | W | Live compare register |
| match_pulse | output | 1 | One-cycle pulse per unblocked hit |
| match_flag | output | 1 | Sticky match flag |
| oc_bit | output | 1 | Internal output-compare bit |
| pin_out | output | 1 | Value driven toward the pin |

## Verification
The bench checks that a counter write blocks the first later tick even after a long stopped gap. A design that clears the block on the next clock instead of the next tick would raise a flag and toggle the output where none should appear. It checks that PWM compare writes stay in the shadow until the right end of the period. A design that loads at the wrong end, or loads at once, would change cmp_active at the wrong tick. A design that lets a force raise the flag, or that honours force in PWM, would fail the force cases. The bench also checks a hit in the same cycle as a flag clear, where a design that gives the clear priority would drop the flag. It checks the pin source for each mode pair and checks that out_mode changes take effect at once.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

   typedef enum logic [1:0] {
      WM_NORMAL = 2'b00,
      WM_CLRMAT = 2'b01,
      WM_FPWM   = 2'b10,
      WM_PCPWM  = 2'b11
   } wave_mode_e;

   typedef enum logic [1:0] {
      OM_OFF    = 2'b00,
      OM_TOGGLE = 2'b01,
      OM_CLEAR  = 2'b10,
      OM_SET    = 2'b11
   } out_mode_e;

   function automatic logic is_pwm(input logic [1:0] wm);
      return wm[1];
   endfunction

   function automatic logic apply_action(input logic [1:0] om, input logic cur);
      case (om)
         OM_TOGGLE: return ~cur;
         OM_CLEAR:  return 1'b0;
         OM_SET:    return 1'b1;
         default:   return cur;
      endcase
   endfunction

endpackage

// File: rtl/ocu_cmp_store.sv
module ocu_cmp_store #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   wave_mode,
   input  logic         tick,
   input  logic         cnt_at_top,
   input  logic         cnt_at_bottom,
   input  logic         cmp_wr,
   input  logic [W-1:0] cmp_wdata,
   output logic [W-1:0] cmp_active
);
   import ocu_pkg::*;

   logic [W-1:0] shadow_q;
   logic [W-1:0] active_q;
   logic         pwm;
   logic         period_end;

   assign pwm = is_pwm(wave_mode);

   always_comb begin
      case (wave_mode)
         WM_FPWM:  period_end = tick & cnt_at_top;
         WM_PCPWM: period_end = tick & cnt_at_bottom;
         default:  period_end = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= '0;
         active_q <= '0;
      end else begin
         if (cmp_wr) shadow_q <= cmp_wdata;
         if (!pwm) begin
            if (cmp_wr) active_q <= cmp_wdata;
         end else if (period_end) begin
            active_q <= shadow_q;
         end
      end
   end

   assign cmp_active = active_q;
endmodule

// File: rtl/ocu_match_det.sv
module ocu_match_det #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] cnt_val,
   input  logic [W-1:0] cmp_active,
   input  logic         cnt_wr,
   output logic         hit,
   output logic         match_pulse
);
   logic block_q;
   logic pulse_q;

   assign hit = tick & ~block_q & (cnt_val == cmp_active);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         block_q <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         if (cnt_wr)    block_q <= 1'b1;
         else if (tick) block_q <= 1'b0;
         pulse_q <= hit;
      end
   end

   assign match_pulse = pulse_q;
endmodule

// File: rtl/ocu_wavegen.sv
module ocu_wavegen (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] wave_mode,
   input  logic [1:0] out_mode,
   input  logic       tick,
   input  logic       cnt_at_bottom,
   input  logic       hit,
   input  logic       force_stb,
   input  logic       flag_clr,
   output logic       oc_bit,
   output logic       match_flag
);
   import ocu_pkg::*;

   logic oc_q, oc_d;
   logic flag_q;
   logic pwm;

   assign pwm = is_pwm(wave_mode);

   always_comb begin
      oc_d = oc_q;
      if (!pwm) begin
         if (hit || force_stb) oc_d = apply_action(out_mode, oc_q);
      end else begin
         if (hit) begin
            if (out_mode == OM_CLEAR)    oc_d = 1'b0;
            else if (out_mode == OM_SET) oc_d = 1'b1;
         end else if (tick && cnt_at_bottom) begin
            if (out_mode == OM_CLEAR)    oc_d = 1'b1;
            else if (out_mode == OM_SET) oc_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oc_q   <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         oc_q <= oc_d;
         if (hit)           flag_q <= 1'b1;
         else if (flag_clr) flag_q <= 1'b0;
      end
   end

   assign oc_bit     = oc_q;
   assign match_flag = flag_q;
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel #(
   parameter int W       = 8,
   parameter bit PIN_REG = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] cnt_val,
   input  logic         cnt_at_top,
   input  logic         cnt_at_bottom,
   input  logic [1:0]   wave_mode,
   input  logic [1:0]   out_mode,
   input  logic         cmp_wr,
   input  logic [W-1:0] cmp_wdata,
   input  logic         cnt_wr,
   input  logic         force_stb,
   input  logic         flag_clr,
   input  logic         port_val,
   output logic [W-1:0] cmp_active,
   output logic         match_pulse,
   output logic         match_flag,
   output logic         oc_bit,
   output logic         pin_out
);
   import ocu_pkg::*;

   localparam int MAX_W = 32;

   generate
      if (W < 2 || W > MAX_W) begin : g_bad_width
         $error("ocu_channel: W out of range");
      end
   endgenerate

   logic hit;
   logic pin_sel_port;
   logic pin_next;

   ocu_cmp_store #(.W(W)) u_store (
      .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .tick(tick),
      .cnt_at_top(cnt_at_top), .cnt_at_bottom(cnt_at_bottom),
      .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cmp_active(cmp_active)
   );

   ocu_match_det #(.W(W)) u_match (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val),
      .cmp_active(cmp_active), .cnt_wr(cnt_wr),
      .hit(hit), .match_pulse(match_pulse)
   );

   ocu_wavegen u_wave (
      .clk(clk), .rst_n(rst_n), .wave_mode(wave_mode), .out_mode(out_mode),
      .tick(tick), .cnt_at_bottom(cnt_at_bottom), .hit(hit),
      .force_stb(force_stb & ~is_pwm(wave_mode)), .flag_clr(flag_clr),
      .oc_bit(oc_bit), .match_flag(match_flag)
   );

   assign pin_sel_port = (out_mode == OM_OFF) ||
                         (is_pwm(wave_mode) && out_mode == OM_TOGGLE);
   assign pin_next     = pin_sel_port ? port_val : oc_bit;

   generate
      if (PIN_REG) begin : g_pin_reg
         logic pin_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pin_q <= 1'b0;
            else        pin_q <= pin_next;
         end
         assign pin_out = pin_q;
      end else begin : g_pin_comb
         assign pin_out = pin_next;
      end
   endgenerate
endmodule

// File: rtl/ocu_channel_chk.sv
module ocu_channel_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic [1:0]   wave_mode,
   input logic         cmp_wr,
   input logic [W-1:0] cmp_wdata,
   input logic         cnt_wr,
   input logic         force_stb,
   input logic         flag_clr,
   input logic [W-1:0] cmp_active,
   input logic         match_pulse,
   input logic         match_flag,
   input logic         oc_bit
);
   a_r1_direct_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!wave_mode[1] && cmp_wr) |=> (cmp_active == $past(cmp_wdata)));

   a_r2_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_mode[1] && !tick) |=> $stable(cmp_active));

   a_r3_oc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !force_stb) |=> $stable(oc_bit));

   a_r5_cnt_block: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr ##1 tick) |=> !match_pulse);

   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (match_flag && !flag_clr) |=> match_flag);

   a_r6_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(match_flag) |-> match_pulse);
endmodule

bind ocu_channel ocu_channel_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .wave_mode(wave_mode),
   .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .cnt_wr(cnt_wr),
   .force_stb(force_stb), .flag_clr(flag_clr), .cmp_active(cmp_active),
   .match_pulse(match_pulse), .match_flag(match_flag), .oc_bit(oc_bit)
);

// File: tb/sim_ocu_channel.sv
`timescale 1ns/1ps
module sim_ocu_channel;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [7:0] cnt_val = '0;
   logic       cnt_at_top = 1'b0;
   logic       cnt_at_bottom = 1'b0;
   logic [1:0] wave_mode = 2'b00;
   logic [1:0] out_mode = 2'b00;
   logic       cmp_wr = 1'b0;
   logic [7:0] cmp_wdata = '0;
   logic       cnt_wr = 1'b0;
   logic       force_stb = 1'b0;
   logic       flag_clr = 1'b0;
   logic       port_val = 1'b1;
   logic [7:0] cmp_active;
   logic       match_pulse, match_flag, oc_bit, pin_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ocu_channel #(.W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val),
      .cnt_at_top(cnt_at_top), .cnt_at_bottom(cnt_at_bottom),
      .wave_mode(wave_mode), .out_mode(out_mode), .cmp_wr(cmp_wr),
      .cmp_wdata(cmp_wdata), .cnt_wr(cnt_wr), .force_stb(force_stb),
      .flag_clr(flag_clr), .port_val(port_val), .cmp_active(cmp_active),
      .match_pulse(match_pulse), .match_flag(match_flag), .oc_bit(oc_bit),
      .pin_out(pin_out)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step_edge();
      @(posedge clk);
      #1;
   endtask

   task automatic do_tick(input logic [7:0] c, input logic top, input logic bot);
      @(negedge clk);
      tick = 1'b1; cnt_val = c; cnt_at_top = top; cnt_at_bottom = bot;
      step_edge();
      tick = 1'b0; cnt_at_top = 1'b0; cnt_at_bottom = 1'b0;
   endtask

   task automatic write_cmp(input logic [7:0] v);
      @(negedge clk);
      cmp_wr = 1'b1; cmp_wdata = v;
      step_edge();
      cmp_wr = 1'b0;
   endtask

   task automatic write_cnt();
      @(negedge clk);
      cnt_wr = 1'b1;
      step_edge();
      cnt_wr = 1'b0;
   endtask

   task automatic do_force();
      @(negedge clk);
      force_stb = 1'b1;
      step_edge();
      force_stb = 1'b0;
   endtask

   task automatic clear_flag();
      @(negedge clk);
      flag_clr = 1'b1;
      step_edge();
      flag_clr = 1'b0;
   endtask

   task automatic t_reset();
      check("R10 reset oc", oc_bit, 0);
      check("R10 reset flag", match_flag, 0);
      check("R10 reset cmp", cmp_active, 0);
      check("R8 pin port when off", pin_out, 1);
   endtask

   task automatic t_direct();
      write_cmp(8'h40);
      check("R1 direct write", cmp_active, 8'h40);
   endtask

   task automatic t_toggle();
      out_mode = 2'b01; port_val = 1'b0;
      do_tick(8'h3F, 0, 0);
      check("R3 no hit oc", oc_bit, 0);
      check("R6 no hit pulse", match_pulse, 0);
      do_tick(8'h40, 0, 0);
      check("R3 toggle on hit", oc_bit, 1);
      check("R6 flag set", match_flag, 1);
      check("R6 pulse", match_pulse, 1);
      check("R8 pin follows oc", pin_out, 1);
      step_edge();
      check("R6 pulse one cycle", match_pulse, 0);
      do_tick(8'h40, 0, 0);
      check("R3 toggle back", oc_bit, 0);
   endtask

   task automatic t_flag();
      clear_flag();
      check("R6 flag cleared", match_flag, 0);
      @(negedge clk);
      flag_clr = 1'b1; tick = 1'b1; cnt_val = 8'h40;
      step_edge();
      flag_clr = 1'b0; tick = 1'b0;
      check("R6 hit beats clear", match_flag, 1);
      check("R3 toggle same edge", oc_bit, 1);
   endtask

   task automatic t_setclr();
      out_mode = 2'b10;
      do_tick(8'h40, 0, 0);
      check("R3 clear on hit", oc_bit, 0);
      out_mode = 2'b11;
      do_tick(8'h40, 0, 0);
      check("R7 set right after mode change", oc_bit, 1);
      out_mode = 2'b00;
      do_tick(8'h40, 0, 0);
      check("R3 off mode keeps oc", oc_bit, 1);
   endtask

   task automatic t_force();
      clear_flag();
      out_mode = 2'b01;
      do_force();
      check("R4 force toggles", oc_bit, 0);
      check("R4 force no flag", match_flag, 0);
      check("R4 force no pulse", match_pulse, 0);
      out_mode = 2'b11;
      do_force();
      check("R4 force set", oc_bit, 1);
   endtask

   task automatic t_block();
      out_mode = 2'b01;
      write_cnt();
      do_tick(8'h40, 0, 0);
      check("R5 blocked pulse", match_pulse, 0);
      check("R5 blocked oc", oc_bit, 1);
      check("R5 blocked flag", match_flag, 0);
      do_tick(8'h40, 0, 0);
      check("R5 next tick hits", oc_bit, 0);
      clear_flag();
      write_cnt();
      for (int i = 0; i < 10; i++) step_edge();
      do_tick(8'h40, 0, 0);
      check("R5 stopped blocked oc", oc_bit, 0);
      check("R5 stopped blocked flag", match_flag, 0);
   endtask

   task automatic t_pwm_buf();
      out_mode = 2'b10;
      wave_mode = 2'b10;
      write_cmp(8'h80);
      check("R2 fast shadow hold", cmp_active, 8'h40);
      do_tick(8'h10, 0, 0);
      check("R2 fast no load mid", cmp_active, 8'h40);
      do_tick(8'hFF, 1, 0);
      check("R2 fast load at top", cmp_active, 8'h80);
      wave_mode = 2'b11;
      write_cmp(8'h20);
      do_tick(8'hFF, 1, 0);
      check("R2 phase no load at top", cmp_active, 8'h80);
      do_tick(8'h00, 0, 1);
      check("R2 phase load at bottom", cmp_active, 8'h20);
   endtask

   task automatic t_pwm_wave();
      wave_mode = 2'b10;
      out_mode = 2'b10;
      clear_flag();
      do_tick(8'h00, 0, 1);
      check("R9 set at bottom", oc_bit, 1);
      do_tick(8'h20, 0, 0);
      check("R9 clear on hit", oc_bit, 0);
      check("R6 pwm flag", match_flag, 1);
      out_mode = 2'b11;
      do_tick(8'h00, 0, 1);
      check("R9 inverted bottom", oc_bit, 0);
      do_tick(8'h20, 0, 0);
      check("R9 inverted hit", oc_bit, 1);
      out_mode = 2'b01;
      do_force();
      check("R4 force ignored in pwm", oc_bit, 1);
      port_val = 1'b0;
      #1;
      check("R8 pwm 01 uses port", pin_out, 0);
      do_tick(8'h20, 0, 0);
      check("R9 pwm 01 no action", oc_bit, 1);
      wave_mode = 2'b00;
      step_edge();
      check("R10 oc kept across mode", oc_bit, 1);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_direct();
      t_toggle();
      t_flag();
      t_setclr();
      t_force();
      t_block();
      t_pwm_buf();
      t_pwm_wave();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule